// File: doc/BRIEF.md
# APB Register Splitter and Forwarder

This block is an APB completer whose 13-bit address space is cut into two 4 KB halves. The lower half lands on a small bank of control registers held inside the block. The upper half is bridged out through an APB requester port to an external register bank whose latency is unknown. Internal accesses finish at once and never report an error. External accesses are held open until the external bank answers. Its wait states, read data and error flag are then passed back to the initiator unchanged.

The APB handshake is the block's flow control on both sides. On the upstream side, the completer ready (`up_ready`) is the back-pressure signal. The initiator must keep address, direction, data and strobes stable from its setup phase until the cycle in which `up_ready` is high. On the downstream side the block behaves the same way: it keeps its request stable until `dn_ready` is sampled high. A downstream transfer begins only from a fresh upstream setup phase, so one upstream transfer never produces two downstream transfers.

Top module: `apb_split_fwd`

## Requirements
- R1: Address bit 12 picks the target: 0 selects the internal bank, 1 selects the external port. An internal access never asserts `dn_sel`.
- R2: An internal access asserts `up_ready` in its first access-phase cycle, with zero wait states.
- R3: An internal access never asserts `up_err`, and this includes reserved addresses.
- R4: An internal write changes a register only when `up_strb` is 4'b1111. Any other strobe pattern leaves every register unchanged.
- R5: The internal bank holds four 32-bit read/write registers at byte offsets 0x000, 0x004, 0x008 and 0x00C. A read returns the last full-strobe value written.
- R6: Every other internal offset, misaligned offsets included, is reserved. A read of one returns 32'h0, and a write to one changes no register.
- R7: An external access drives a downstream setup cycle (`dn_sel`=1, `dn_enable`=0) in the cycle after the upstream setup phase, then access cycles (`dn_enable`=1). During both it carries `up_addr[11:0]`, the write flag, the write data and the strobes unmodified, so partial-byte writes reach the external bank.
- R8: For an external access, `up_ready` rises in the cycle that `dn_ready` is high during the downstream access phase, and in no earlier cycle. Each downstream wait state adds one upstream wait state.
- R9: In the external completion cycle, `up_rdata` equals `dn_rdata` and `up_err` equals `dn_err`.
- R10: After a downstream completion, `dn_sel` is low on the next cycle. It stays low until a new upstream setup phase addresses the external half.
- R11: Reset clears all internal registers to zero and leaves `dn_sel` and `dn_enable` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_sel | input | 1 | Upstream select |
| up_enable | input | 1 | Upstream access-phase flag |
| up_addr | input | 13 | Upstream byte address; bit 12 picks the half |
| up_write | input | 1 | Upstream direction, 1 = write |
| up_wdata | input | 32 | Upstream write data |
| up_strb | input | 4 | Upstream byte strobes |
| up_rdata | output | 32 | Read data returned to the initiator |
| up_ready | output | 1 | Completion / back-pressure to the initiator |
| up_err | output | 1 | Error response to the initiator |
| dn_sel | output | 1 | Downstream select |
| dn_enable | output | 1 | Downstream access-phase flag |
| dn_addr | output | 12 | Downstream byte address |
| dn_write | output | 1 | Downstream direction |
| dn_wdata | output | 32 | Downstream write data |
| dn_strb | output | 4 | Downstream byte strobes |
| dn_rdata | input | 32 | Read data from the external bank |
| dn_ready | input | 1 | External bank ready |
| dn_err | input | 1 | External bank error |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the external completion and the error return. The bench's model of the external bank flags an error on any offset whose bits 11:8 are 0xE. It does this in its ready cycle, for read data and for writes, and with zero and non-zero wait counts. The bench then expects `up_ready`, `up_err` and `up_rdata` together in exactly that cycle. The second pair is a partial-strobe upstream write and the register update that it must suppress, or, on the external side, the byte merge that it must carry through. The bench judges both by reading the target back through the normal port and comparing against its own byte-merged shadow copies.

// File: rtl/apb_split_pkg.sv
package apb_split_pkg;
  typedef enum logic [1:0] {
    FWD_IDLE   = 2'd0,
    FWD_SETUP  = 2'd1,
    FWD_ACCESS = 2'd2
  } fwd_state_e;
endpackage

// File: rtl/apb_reg_bank.sv
module apb_reg_bank #(
  parameter int LOC_W    = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic [LOC_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] strb,
  output logic [DATA_W-1:0] rdata
);
  localparam int STRB_W   = DATA_W / 8;
  localparam int BYTE_LSB = $clog2(STRB_W);
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int UP_LSB   = BYTE_LSB + IDX_W;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0]             sel;
  logic [IDX_W-1:0]                idx;
  logic                            aligned, upper_zero, hit, full;

  assign idx        = addr[BYTE_LSB +: IDX_W];
  assign aligned    = (addr[BYTE_LSB-1:0] == '0);
  assign upper_zero = (addr[LOC_W-1:UP_LSB] == '0);
  assign full       = &strb;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = aligned && upper_zero && (idx == IDX_W'(i));
  end

  assign hit = |sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (acc && wr && full && sel[i]) regs[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rdata = regs[i];
    end
  end

  // R4
  partial_strb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && !full) |=> $stable(regs));

  // R6
  reserved_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && !hit) |=> $stable(regs));

  // R6
  reserved_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit) |-> (rdata == '0));
endmodule

// File: rtl/apb_fwd_fsm.sv
module apb_fwd_fsm
  import apb_split_pkg::*;
#(
  parameter int LOC_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LOC_W-1:0]    addr,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] strb,
  input  logic                dn_ready,
  output logic                dn_sel,
  output logic                dn_enable,
  output logic [LOC_W-1:0]    dn_addr,
  output logic                dn_write,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_strb,
  output logic                done
);
  fwd_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= FWD_IDLE;
      dn_addr  <= '0;
      dn_write <= 1'b0;
      dn_wdata <= '0;
      dn_strb  <= '0;
    end else begin
      unique case (state)
        FWD_IDLE: begin
          if (start) begin
            state    <= FWD_SETUP;
            dn_addr  <= addr;
            dn_write <= wr;
            dn_wdata <= wdata;
            dn_strb  <= strb;
          end
        end
        FWD_SETUP:  state <= FWD_ACCESS;
        FWD_ACCESS: if (dn_ready) state <= FWD_IDLE;
        default:    state <= FWD_IDLE;
      endcase
    end
  end

  assign dn_sel    = (state != FWD_IDLE);
  assign dn_enable = (state == FWD_ACCESS);
  assign done      = (state == FWD_ACCESS) && dn_ready;

  // R7
  setup_to_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_sel && !dn_enable) |=> (dn_sel && dn_enable));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_enable && !dn_ready) |=> (dn_enable && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_strb)));

  // R10
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_enable && dn_ready) |=> !dn_sel);

  // R10
  start_only_on_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_sel) |-> $past(start));
endmodule

// File: rtl/apb_split_fwd.sv
module apb_split_fwd #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_sel,
  input  logic                up_enable,
  input  logic [ADDR_W-1:0]   up_addr,
  input  logic                up_write,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [DATA_W/8-1:0] up_strb,
  output logic [DATA_W-1:0]   up_rdata,
  output logic                up_ready,
  output logic                up_err,
  output logic                dn_sel,
  output logic                dn_enable,
  output logic [ADDR_W-2:0]   dn_addr,
  output logic                dn_write,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_strb,
  input  logic [DATA_W-1:0]   dn_rdata,
  input  logic                dn_ready,
  input  logic                dn_err
);
  localparam int LOC_W = ADDR_W - 1;

  logic              is_ext, int_acc, ext_acc, ext_start, fwd_done;
  logic [DATA_W-1:0] bank_rdata;

  assign is_ext    = up_addr[ADDR_W-1];
  assign int_acc   = up_sel && up_enable && !is_ext;
  assign ext_acc   = up_sel && up_enable && is_ext;
  assign ext_start = up_sel && !up_enable && is_ext;

  apb_reg_bank #(
    .LOC_W(LOC_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (int_acc),
    .wr    (up_write),
    .addr  (up_addr[LOC_W-1:0]),
    .wdata (up_wdata),
    .strb  (up_strb),
    .rdata (bank_rdata)
  );

  apb_fwd_fsm #(
    .LOC_W(LOC_W), .DATA_W(DATA_W)
  ) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ext_start),
    .addr      (up_addr[LOC_W-1:0]),
    .wr        (up_write),
    .wdata     (up_wdata),
    .strb      (up_strb),
    .dn_ready  (dn_ready),
    .dn_sel    (dn_sel),
    .dn_enable (dn_enable),
    .dn_addr   (dn_addr),
    .dn_write  (dn_write),
    .dn_wdata  (dn_wdata),
    .dn_strb   (dn_strb),
    .done      (fwd_done)
  );

  always_comb begin
    up_ready = 1'b0;
    up_err   = 1'b0;
    up_rdata = '0;
    if (int_acc) begin
      up_ready = 1'b1;
      up_rdata = bank_rdata;
    end else if (ext_acc && fwd_done) begin
      up_ready = 1'b1;
      up_err   = dn_err;
      up_rdata = dn_rdata;
    end
  end

  // R1
  internal_stays_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_sel && !is_ext) |-> !dn_sel);

  // R2
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_sel && !up_enable && !is_ext) |=> (!up_enable || up_ready));

  // R3
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_err |-> (dn_err && dn_enable && is_ext));

  // R8
  ext_ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready && is_ext) |-> (dn_ready && dn_enable));
endmodule

// File: tb/apb_split_fwd_bench.sv
module apb_split_fwd_bench;
  localparam int AW = 13;
  localparam int DW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          up_sel = 1'b0, up_enable = 1'b0, up_write = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic [SW-1:0] up_strb = '0;
  logic [DW-1:0] up_rdata;
  logic          up_ready, up_err;
  logic          dn_sel, dn_enable, dn_write;
  logic [AW-2:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic [SW-1:0] dn_strb;
  logic [DW-1:0] dn_rdata;
  logic          dn_ready, dn_err;

  apb_split_fwd u_apb_split_fwd (
    .clk(clk), .rst_n(rst_n),
    .up_sel(up_sel), .up_enable(up_enable), .up_addr(up_addr), .up_write(up_write),
    .up_wdata(up_wdata), .up_strb(up_strb), .up_rdata(up_rdata), .up_ready(up_ready),
    .up_err(up_err), .dn_sel(dn_sel), .dn_enable(dn_enable), .dn_addr(dn_addr),
    .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_strb(dn_strb), .dn_rdata(dn_rdata),
    .dn_ready(dn_ready), .dn_err(dn_err)
  );

  // External bank model: variable wait count, error on offsets 0xE00-0xEFF
  logic [DW-1:0] ext_mem [16];
  logic [DW-1:0] ext_ref [16];
  logic [DW-1:0] ref_regs [4];
  int ext_wait = 0;
  int wait_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;

  assign dn_ready = dn_sel && dn_enable && (wait_cnt >= ext_wait);
  assign dn_rdata = dn_ready ? ext_mem[dn_addr[5:2]] : 32'hDEAD_BEEF;
  assign dn_err   = dn_ready && (dn_addr[11:8] == 4'hE);

  always @(posedge clk) begin
    if (dn_sel && dn_enable && !dn_ready) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (dn_ready && dn_write)
      for (int b = 0; b < SW; b++)
        if (dn_strb[b]) ext_mem[dn_addr[5:2]][8*b +: 8] <= dn_wdata[8*b +: 8];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // One full upstream transfer, compared against the model on every clock
  task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [31:0] d,
                      input logic [3:0] st, input string req);
    logic ext, hit, exp_err, exp_rdy, fin;
    logic [1:0] idx;
    logic [31:0] exp_rd;
    int k;
    ext = a[12];
    idx = a[3:2];
    hit = (a[11:4] == 8'h0) && (a[1:0] == 2'b00);
    if (!ext) begin
      exp_rd  = hit ? ref_regs[idx] : 32'h0;
      exp_err = 1'b0;
    end else begin
      exp_rd  = ext_ref[a[5:2]];
      exp_err = (a[11:8] == 4'hE);
    end
    @(posedge clk); #1;
    up_sel = 1'b1; up_enable = 1'b0; up_addr = a; up_write = w; up_wdata = d; up_strb = st;
    @(negedge clk);
    chk(req, "dn_sel in upstream setup", {31'b0, dn_sel}, 32'h0);
    @(posedge clk); #1;
    up_enable = 1'b1;
    k = 1;
    fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      exp_rdy = ext ? (k == 2 + ext_wait) : (k == 1);
      chk(ext ? "R7" : "R1", "dn_sel", {31'b0, dn_sel}, {31'b0, ext});
      chk("R7", "dn_enable", {31'b0, dn_enable}, {31'b0, ext && (k >= 2)});
      if (ext && dn_sel) begin
        chk("R7", "dn_addr", {20'b0, dn_addr}, {20'b0, a[11:0]});
        chk("R7", "dn_write", {31'b0, dn_write}, {31'b0, w});
        chk("R7", "dn_strb", {28'b0, dn_strb}, {28'b0, st});
        if (w) chk("R7", "dn_wdata", dn_wdata, d);
      end
      chk(ext ? "R8" : "R2", "up_ready", {31'b0, up_ready}, {31'b0, exp_rdy});
      if (exp_rdy || up_ready) begin
        chk(ext ? "R9" : "R3", "up_err", {31'b0, up_err}, {31'b0, exp_err});
        if (!w) chk(ext ? "R9" : (hit ? "R5" : "R6"), "up_rdata", up_rdata, exp_rd);
        fin = 1'b1;
      end else if (k > 40) begin
        chk(req, "transfer timeout", 32'h1, 32'h0);
        fin = 1'b1;
      end else begin
        @(posedge clk); #1;
        k++;
      end
    end
    if (w) begin
      if (!ext && hit && st == 4'hF) ref_regs[idx] = d;
      if (ext)
        for (int b = 0; b < SW; b++)
          if (st[b]) ext_ref[a[5:2]][8*b +: 8] = d[8*b +: 8];
    end
    @(posedge clk); #1;
    up_sel = 1'b0; up_enable = 1'b0;
    @(negedge clk);
    chk("R10", "dn_sel after completion", {31'b0, dn_sel}, 32'h0);
    chk("R10", "up_ready while idle", {31'b0, up_ready}, 32'h0);
  endtask

  task automatic idle_watch(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R10", "dn_sel with no upstream setup", {31'b0, dn_sel}, 32'h0);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) ref_regs[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "dn_sel in reset", {31'b0, dn_sel}, 32'h0);
    chk("R11", "dn_enable in reset", {31'b0, dn_enable}, 32'h0);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      ext_mem[i] = 32'h0101_0101 * i;
      ext_ref[i] = 32'h0101_0101 * i;
    end
    do_reset();
    // R11 / R5: all registers read zero after reset
    for (int i = 0; i < 4; i++) xfer(13'(4 * i), 1'b0, 32'h0, 4'h0, "R11");
    // R5: full-strobe writes then reads
    xfer(13'h000, 1'b1, 32'hA5A5_0001, 4'hF, "R5");
    xfer(13'h004, 1'b1, 32'h1234_5678, 4'hF, "R5");
    xfer(13'h008, 1'b1, 32'hCAFE_F00D, 4'hF, "R5");
    xfer(13'h00C, 1'b1, 32'hFFFF_0000, 4'hF, "R5");
    for (int i = 0; i < 4; i++) xfer(13'(4 * i), 1'b0, 32'h0, 4'h0, "R5");
    // R4: partial strobes leave register 1 unchanged
    xfer(13'h004, 1'b1, 32'h0000_0000, 4'b0111, "R4");
    xfer(13'h004, 1'b1, 32'hFFFF_FFFF, 4'b0001, "R4");
    xfer(13'h004, 1'b1, 32'h5555_5555, 4'b0000, "R4");
    xfer(13'h004, 1'b0, 32'h0, 4'h0, "R4");
    // R6: reserved writes dropped, reserved reads zero
    xfer(13'h010, 1'b1, 32'h1111_1111, 4'hF, "R6");
    xfer(13'h800, 1'b1, 32'h2222_2222, 4'hF, "R6");
    xfer(13'h006, 1'b1, 32'h3333_3333, 4'hF, "R6");
    xfer(13'h010, 1'b0, 32'h0, 4'h0, "R6");
    xfer(13'hFFC, 1'b0, 32'h0, 4'h0, "R6");
    xfer(13'h002, 1'b0, 32'h0, 4'h0, "R6");
    for (int i = 0; i < 4; i++) xfer(13'(4 * i), 1'b0, 32'h0, 4'h0, "R6");
    // R7/R8/R9: external path, zero and non-zero waits
    ext_wait = 0;
    xfer(13'h1004, 1'b1, 32'hBEEF_0004, 4'hF, "R7");
    xfer(13'h1004, 1'b0, 32'h0, 4'h0, "R9");
    idle_watch(3);
    ext_wait = 3;
    xfer(13'h1008, 1'b1, 32'h0BAD_CAFE, 4'hF, "R8");
    xfer(13'h1008, 1'b0, 32'h0, 4'h0, "R8");
    // R7: partial strobe reaches the external bank
    ext_wait = 1;
    xfer(13'h1004, 1'b1, 32'h1122_3344, 4'b0101, "R7");
    xfer(13'h1004, 1'b0, 32'h0, 4'h0, "R7");
    // R9: errors with data, zero and multi-cycle waits
    ext_wait = 0;
    xfer(13'h1E00, 1'b0, 32'h0, 4'h0, "R9");
    ext_wait = 2;
    xfer(13'h1E04, 1'b1, 32'h7777_7777, 4'hF, "R9");
    xfer(13'h1E04, 1'b0, 32'h0, 4'h0, "R9");
    // R1: internal access right after external keeps downstream quiet
    xfer(13'h008, 1'b0, 32'h0, 4'h0, "R1");
    idle_watch(4);
    // R11: reset again clears the bank
    do_reset();
    for (int i = 0; i < 4; i++) xfer(13'(4 * i), 1'b0, 32'h0, 4'h0, "R11");
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end
endmodule